// File: doc/BRIEF.md
# Serial Bus Register Port (two-wire slave)

This block is the target side of a two-wire I2C-style serial bus. It gives a bus host read and write access to a small register file that lives in a neighbouring block. The two bus lines arrive as plain level inputs sampled by the system clock. Each line passes through a synchronizer and a majority filter, and the block then finds clock edges and the start and stop conditions. The block's only bus output is an enable that pulls the data line low. An external pull-up produces every high level on the bus.

A write is an identification byte, a register index byte and one data byte. The block acknowledges all three and emits a single write strobe that carries the index and the data. A read first sets the index with a short write and then issues a repeated start and an identification byte with the read bit set. The block then streams the indexed register for as long as the host acknowledges each byte. Before each byte it raises a one-cycle read request to the register file, which must present the data on the next clock. The index does not advance between bytes. The block ignores the bus entirely while the power-up recall input is still low.

Top module: `i2c_regport`

## Requirements
- R1: After reset, and whenever the block is not sending an acknowledge or a data bit, `sda_pull` is 0. The block never drives the data line high.
- R2: The block acknowledges an identification byte (driving the ninth bit low) exactly when its bits 7..3 are 01010, bit 2 equals `addr_sel` and bit 1 is 0. Bit 0 is the transfer direction: 0 means write and 1 means read.
- R3: A write (START, matching identification byte with bit 0 = 0, index byte, data byte, STOP) acknowledges all three bytes. It gives one single-cycle `reg_wr_en` pulse, with `reg_addr` equal to the index byte and `reg_wr_data` equal to the data byte.
- R4: A read (START, write identification byte, index byte, repeated START, identification byte with bit 0 = 1) acknowledges all three bytes. It then returns the indexed register MSB first. A data bit of 1 is sent as a released line and a data bit of 0 as a pulled line.
- R5: While the host acknowledges each returned byte, the block keeps sending further bytes of the same index. Each returned byte is preceded by exactly one single-cycle `reg_rd_en` pulse.
- R6: After the host leaves a returned byte unacknowledged, the block releases the data line. It sends nothing more and makes no more read requests until the next START or STOP.
- R7: Data bytes that follow the first data byte of a write are not acknowledged and produce no write strobe.
- R8: While `boot_done` is 0, START conditions are ignored. The block stays idle and never pulls the data line.
- R9: A STOP seen at any point returns the block to idle. A byte sent after that without a new START is not acknowledged.
- R10: A low pulse on a bus line that lasts one clock cycle is filtered out and has no effect. A low pulse of four cycles on the data line while the clock line is high is seen as a START followed by a STOP, and it aborts the transfer.
- R11: Outgoing data changes only while the bus clock line is low, so each sent bit holds its value through the whole high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_done | input | 1 | High once the power-up recall has finished; the bus is ignored while low |
| addr_sel | input | 1 | Pin-selected bit 2 of the identification byte |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull | output | 1 | When 1, the open-drain data pad pulls the line low |
| reg_addr | output | 8 | Latched register index |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_data | output | 8 | Data byte for the write strobe |
| reg_rd_en | output | 1 | One-cycle read request; data expected on `reg_rd_data` the next cycle |
| reg_rd_data | input | 8 | Read data from the register file |

## Verification
The bench builds the block with a two-stage synchronizer and a three-sample majority window. With that window, a single-cycle glitch must disappear and a four-cycle pulse must get through, so both sides of the filter threshold are exercised. The bus runs at 32 system clocks per bit, slow enough that the filter delay never reorders data changes against clock edges. This makes every bit of the identification byte reachable: all 128 upper-seven-bit patterns are swept with `addr_sel` high, and a pair of cases is repeated with it low. The register file attached to the block has three entries, so every index is written, read back and streamed with host acknowledges.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

  localparam int BYTE_W = 8;
  localparam logic [4:0] ID_PREFIX = 5'b01010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_END,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_HOLD
  } xfer_st_t;

  typedef enum logic [1:0] {
    K_ID,
    K_REG,
    K_DATA
  } byte_kind_t;

  typedef enum logic [1:0] {
    AF_RX,
    AF_TX,
    AF_HOLD
  } after_ack_t;

  // identification byte check: prefix, pin bit, forced zero; bit 0 is direction
  function automatic logic id_match(input logic [BYTE_W-1:0] b, input logic sel);
    return (b[7:3] == ID_PREFIX) && (b[2] == sel) && (b[1] == 1'b0);
  endfunction

  // pull-low enable for one outgoing bit on an open-drain line
  function automatic logic pull_for(input logic bit_val);
    return ~bit_val;
  endfunction

  // shift left by one, filling with zero
  function automatic logic [BYTE_W-1:0] shl1(input logic [BYTE_W-1:0] v);
    return {v[BYTE_W-2:0], 1'b0};
  endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int HALF = FILT_LEN / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    win_q;
  logic                   filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      win_q  <= '1;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      win_q  <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      filt_q <= ($countones(win_q) > HALF);
    end
  end

  assign dout = filt_q;

  // R10: the filtered level can only move toward the sample that just entered the window
  a_r10_change_follows_newest: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> (filt_q == $past(win_q[0])));

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;

endmodule

// File: rtl/i2c_xfer_fsm.sv
module i2c_xfer_fsm
  import i2c_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_done,
  input  logic              addr_sel,
  input  logic              scl_hi,
  input  logic              sda_bit,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_pull,
  output logic [BYTE_W-1:0] reg_addr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_en
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  xfer_st_t          st;
  byte_kind_t        kind;
  after_ack_t        after;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] rx_sr;
  logic [BYTE_W-1:0] tx_sr;
  logic              mack_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      kind      <= K_ID;
      after     <= AF_RX;
      cnt       <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      mack_seen <= 1'b0;
      sda_pull  <= 1'b0;
      reg_addr  <= '0;
      wr_en     <= 1'b0;
      wr_data   <= '0;
      rd_en     <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      rd_en <= 1'b0;
      if (!boot_done) begin
        st        <= ST_IDLE;
        sda_pull  <= 1'b0;
        cnt       <= '0;
        mack_seen <= 1'b0;
      end else if (stop_ev) begin
        st       <= ST_IDLE;
        sda_pull <= 1'b0;
      end else if (start_ev) begin
        st        <= ST_RX;
        kind      <= K_ID;
        cnt       <= '0;
        sda_pull  <= 1'b0;
        mack_seen <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise) begin
              rx_sr <= {rx_sr[BYTE_W-2:0], sda_bit};
              cnt   <= cnt + 1'b1;
              if (cnt == LAST_BIT) st <= ST_RX_END;
            end
          end
          ST_RX_END: begin
            if (scl_fall) begin
              case (kind)
                K_ID: begin
                  if (id_match(rx_sr, addr_sel)) begin
                    sda_pull <= 1'b1;
                    st       <= ST_ACK;
                    if (rx_sr[0]) begin
                      rd_en <= 1'b1;
                      after <= AF_TX;
                    end else begin
                      kind  <= K_REG;
                      after <= AF_RX;
                    end
                  end else begin
                    st <= ST_HOLD;
                  end
                end
                K_REG: begin
                  reg_addr <= rx_sr;
                  kind     <= K_DATA;
                  sda_pull <= 1'b1;
                  st       <= ST_ACK;
                  after    <= AF_RX;
                end
                default: begin
                  wr_en    <= 1'b1;
                  wr_data  <= rx_sr;
                  sda_pull <= 1'b1;
                  st       <= ST_ACK;
                  after    <= AF_HOLD;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              case (after)
                AF_TX: begin
                  sda_pull <= pull_for(rd_data[BYTE_W-1]);
                  tx_sr    <= shl1(rd_data);
                  st       <= ST_TX;
                end
                AF_RX: begin
                  sda_pull <= 1'b0;
                  st       <= ST_RX;
                end
                default: begin
                  sda_pull <= 1'b0;
                  st       <= ST_HOLD;
                end
              endcase
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == LAST_BIT) begin
                sda_pull  <= 1'b0;
                mack_seen <= 1'b0;
                st        <= ST_MACK;
              end else begin
                sda_pull <= pull_for(tx_sr[BYTE_W-1]);
                tx_sr    <= shl1(tx_sr);
                cnt      <= cnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              if (!sda_bit) begin
                rd_en     <= 1'b1;
                mack_seen <= 1'b1;
              end else begin
                st <= ST_HOLD;
              end
            end else if (scl_fall && mack_seen) begin
              mack_seen <= 1'b0;
              cnt       <= '0;
              sda_pull  <= pull_for(rd_data[BYTE_W-1]);
              tx_sr     <= shl1(rd_data);
              st        <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1: the pull-low enable is only ever active while acknowledging or sending
  a_r1_pull_only_when_driving: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> (st == ST_ACK || st == ST_TX));

  // R3: write strobe lasts a single cycle
  a_r3_wr_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R5: read request lasts a single cycle and never coincides with a write
  a_r5_rd_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);
  a_r5_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

  // R8: nothing happens before the power-up recall finishes
  a_r8_idle_before_boot: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_done |=> (st == ST_IDLE && !sda_pull));

  // R9: a stop condition always lands in idle
  a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && boot_done) |=> (st == ST_IDLE && !sda_pull));

  // R11: a sent bit holds through the clock-high phase
  a_r11_tx_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TX && $past(st) == ST_TX && scl_hi && $past(scl_hi)) |-> $stable(sda_pull));

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_regport_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_done,
  input  logic              addr_sel,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  output logic [BYTE_W-1:0] reg_addr,
  output logic              reg_wr_en,
  output logic [BYTE_W-1:0] reg_wr_data,
  output logic              reg_rd_en,
  input  logic [BYTE_W-1:0] reg_rd_data
);
  localparam int N_LINES = 2;
  localparam int IDX_SCL = 0;
  localparam int IDX_SDA = 1;

  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] filt_lines;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  assign raw_lines = {sda_in, scl_in};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_lines[g]),
      .dout (filt_lines[g])
    );
  end

  i2c_cond_detect u_cond (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (filt_lines[IDX_SCL]),
    .sda_f   (filt_lines[IDX_SDA]),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  i2c_xfer_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .boot_done(boot_done),
    .addr_sel (addr_sel),
    .scl_hi   (filt_lines[IDX_SCL]),
    .sda_bit  (filt_lines[IDX_SDA]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .rd_data  (reg_rd_data),
    .sda_pull (sda_pull),
    .reg_addr (reg_addr),
    .wr_en    (reg_wr_en),
    .wr_data  (reg_wr_data),
    .rd_en    (reg_rd_en)
  );

endmodule

// File: tb/i2c_regport_test.sv
`timescale 1ns/1ps
module i2c_regport_test;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_done = 1'b0;
  logic addr_sel = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic glitch_lo = 1'b0;
  logic sda_line;
  logic sda_pull;
  logic [7:0] reg_addr, reg_wr_data, reg_rd_data;
  logic reg_wr_en, reg_rd_en;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int glitch_len = 0;
  int wr_count = 0;
  int rd_count = 0;
  logic [7:0] last_wa, last_wd;
  logic [7:0] bregs [3];
  logic [7:0] exp_regs [3];

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull & ~glitch_lo;

  i2c_regport uut (
    .clk(clk), .rst_n(rst_n), .boot_done(boot_done), .addr_sel(addr_sel),
    .scl_in(scl_m), .sda_in(sda_line), .sda_pull(sda_pull),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data)
  );

  // three-entry register file attached to the port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) bregs[i] <= 8'h00;
      reg_rd_data <= 8'h00;
      wr_count <= 0;
      rd_count <= 0;
      last_wa <= 8'h00;
      last_wd <= 8'h00;
    end else begin
      if (reg_wr_en) begin
        wr_count <= wr_count + 1;
        last_wa <= reg_addr;
        last_wd <= reg_wr_data;
        if (reg_addr < 8'd3) bregs[reg_addr[1:0]] <= reg_wr_data;
      end
      if (reg_rd_en) begin
        rd_count <= rd_count + 1;
        reg_rd_data <= (reg_addr < 8'd3) ? bregs[reg_addr[1:0]] : 8'hA5;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b0; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    sda_m = 1'b0; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic clock_bit(input logic b, output logic s, output logic s_late);
    sda_m = b; tick(Q);
    scl_m = 1'b1;
    if (glitch_len > 0 && b) begin
      tick(2);
      glitch_lo = 1'b1; tick(glitch_len);
      glitch_lo = 1'b0; tick(Q - 2);
      glitch_len = 0;
    end else begin
      tick(Q);
    end
    s = sda_line;
    tick(Q - 1);
    s_late = sda_line;
    tick(1);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic s, sl;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s, sl);
    clock_bit(1'b1, s, sl);
    ack = !s;
  endtask

  // mack = 1: host acknowledges the byte
  task automatic recv_byte(output logic [7:0] b, input bit mack, output int unstable);
    logic s, sl;
    unstable = 0;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s, sl);
      b[i] = s;
      if (s != sl) unstable++;
    end
    clock_bit(mack ? 1'b0 : 1'b1, s, sl);
  endtask

  function automatic bit exp_ack(input logic [7:0] b, input logic sel);
    return (b[7:4] == 4'b0101) && (b[3] == 1'b0) && (b[2] == sel) && (b[1] == 1'b0);
  endfunction

  task automatic do_write(input logic [7:0] idb, input logic [7:0] a, input logic [7:0] d,
                          output bit k0, output bit k1, output bit k2);
    bus_start();
    send_byte(idb, k0);
    send_byte(a, k1);
    send_byte(d, k2);
    bus_stop();
  endtask

  task automatic do_read1(input logic [7:0] a, output logic [7:0] v, output bit allack,
                          output int unstable);
    bit k0, k1, k2;
    bus_start();
    send_byte(8'h54, k0);
    send_byte(a, k1);
    bus_rstart();
    send_byte(8'h55, k2);
    recv_byte(v, 1'b0, unstable);
    bus_stop();
    allack = k0 && k1 && k2;
  endtask

  initial begin : main
    bit k0, k1, k2;
    logic [7:0] v;
    int un, wc0, rc0;
    for (int i = 0; i < 3; i++) exp_regs[i] = 8'h00;
    tick(5);
    // R1: reset state
    check(sda_pull == 1'b0 && reg_wr_en == 1'b0 && reg_rd_en == 1'b0, "R1 reset outputs",
          {sda_pull, reg_wr_en, reg_rd_en}, 0);
    rst_n = 1'b1;
    tick(10);

    // R8: start ignored before boot completes
    bus_start();
    send_byte(8'h54, k0);
    bus_stop();
    check(!k0, "R8 ack before boot", k0, 0);
    check(sda_pull == 1'b0, "R8 pull idle before boot", sda_pull, 0);
    boot_done = 1'b1;
    tick(10);

    // R2: sweep all identification bytes with direction = write
    for (int vv = 0; vv < 128; vv++) begin
      logic [7:0] idb;
      idb = {vv[6:0], 1'b0};
      bus_start();
      send_byte(idb, k0);
      bus_stop();
      check(k0 == exp_ack(idb, 1'b1), "R2 id sweep sel=1", {idb, 7'b0, k0}, {idb, 7'b0, exp_ack(idb, 1'b1)});
    end
    addr_sel = 1'b0;
    tick(4);
    bus_start(); send_byte(8'h50, k0); bus_stop();
    check(k0, "R2 sel=0 match", k0, 1);
    bus_start(); send_byte(8'h54, k0); bus_stop();
    check(!k0, "R2 sel=0 other pin value", k0, 0);
    check(sda_pull == 1'b0, "R1 released after transfer", sda_pull, 0);
    addr_sel = 1'b1;
    tick(4);

    // R3: writes to every index
    for (int a = 0; a < 3; a++) begin
      logic [7:0] d;
      d = 8'(8'h3C + 8'(a) * 8'h51);
      wc0 = wr_count;
      do_write(8'h54, 8'(a), d, k0, k1, k2);
      exp_regs[a] = d;
      check(k0 && k1 && k2, "R3 three acks", {k0, k1, k2}, 3'b111);
      check(wr_count == wc0 + 1, "R3 one strobe", wr_count - wc0, 1);
      check(last_wa == 8'(a) && last_wd == d, "R3 strobe index/data", {last_wa, last_wd}, {8'(a), d});
    end

    // R4 / R11: single-byte reads of each index
    for (int a = 0; a < 3; a++) begin
      bit ok;
      do_read1(8'(a), v, ok, un);
      check(ok, "R4 read acks", ok, 1);
      check(v == exp_regs[a], "R4 read data", v, exp_regs[a]);
      check(un == 0, "R11 bit stable while clock high", un, 0);
    end

    // R5 / R6: multi-byte read of index 1, then host NACK
    rc0 = rd_count;
    bus_start();
    send_byte(8'h54, k0);
    send_byte(8'h01, k1);
    bus_rstart();
    send_byte(8'h55, k2);
    check(k0 && k1 && k2, "R4 multi read acks", {k0, k1, k2}, 3'b111);
    for (int n = 0; n < 3; n++) begin
      recv_byte(v, n < 2, un);
      check(v == exp_regs[1], "R5 repeated byte same index", v, exp_regs[1]);
    end
    check(rd_count == rc0 + 3, "R5 one request per byte", rd_count - rc0, 3);
    recv_byte(v, 1'b0, un);
    check(v == 8'hFF, "R6 released after host nack", v, 8'hFF);
    check(rd_count == rc0 + 3, "R6 no further requests", rd_count - rc0, 3);
    bus_stop();

    // R7: second data byte of a write is refused
    wc0 = wr_count;
    bus_start();
    send_byte(8'h54, k0);
    send_byte(8'h02, k1);
    send_byte(8'h9D, k2);
    exp_regs[2] = 8'h9D;
    send_byte(8'h11, k0);
    bus_stop();
    check(!k0, "R7 extra byte not acked", k0, 0);
    check(wr_count == wc0 + 1, "R7 single strobe", wr_count - wc0, 1);
    do_read1(8'h02, v, k0, un);
    check(v == 8'h9D, "R7 register keeps first data", v, 8'h9D);

    // R9: stop in the middle of a byte, then a byte with no start
    begin
      logic s, sl;
      bus_start();
      for (int i = 7; i >= 4; i--) clock_bit(v[i], s, sl);
      bus_stop();
      scl_m = 1'b0; tick(Q);
      send_byte(8'h54, k0);
      bus_stop();
      check(!k0, "R9 byte without start ignored", k0, 0);
    end

    // R10: one-cycle glitch is filtered
    wc0 = wr_count;
    bus_start();
    send_byte(8'h54, k0);
    send_byte(8'h00, k1);
    glitch_len = 1;
    send_byte(8'hB7, k2);
    bus_stop();
    exp_regs[0] = 8'hB7;
    check(k2 && wr_count == wc0 + 1 && last_wd == 8'hB7, "R10 short glitch ignored",
          {k2, last_wd}, {1'b1, 8'hB7});

    // R10: four-cycle pulse acts as start+stop and aborts
    wc0 = wr_count;
    bus_start();
    send_byte(8'h54, k0);
    send_byte(8'h00, k1);
    glitch_len = 4;
    send_byte(8'hFF, k2);
    bus_stop();
    check(!k2 && wr_count == wc0, "R10 long pulse aborts", {k2, 8'(wr_count - wc0)}, 0);
    do_read1(8'h00, v, k0, un);
    check(v == exp_regs[0], "R10 register unchanged", v, exp_regs[0]);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule